// File: doc/BRIEF.md
# Power Mode Transition Controller

This block tracks the operating mode of a small microcontroller and decides which mode changes are allowed. Software requests a target mode by writing a 4-bit mode code through a simple register write port. In the two sleep modes, an interrupt input, or in the deeper sleep mode also a wakeup input, requests the return to a run mode. Each mode has its own configuration word, written through the same port. That word gives the system clock selection, the flash power state and the clock-source enables. The block drives the word of the current mode, or of the target mode while a change is in progress.

A change that has been accepted stays in progress until the clock-ready inputs cover every enabled clock source and the flash reports ready. Only then does the current-mode output move to the new mode. Requests that are not allowed from the current mode are dropped and raise a sticky flag. Requests made while a change is pending are treated the same way. A configuration that selects the stop code for the system clock freezes the block in its mode until reset. Power domains 0 and 1 are always on. The other domains follow one shared power word.

Top module: `pmode_ctrl`

## Requirements
- R1: After reset the current mode is the default run mode (code 4'b0011), busy and illegal are 0, and the outputs show the reset configuration: system clock 0, flash state 0, only clock source 0 enabled, only domains 0 and 1 on.
- R2: Codes 4'b0100..4'b0111 (Run0..Run3) and 4'b0011 (default run) written to address 0 are accepted when the current mode is the default run mode or a Run mode.
- R3: Code 4'b1000 (Halt) is accepted only from Run0..Run3. From any other mode it is rejected, and the mode stays unchanged.
- R4: busy rises on the clock edge that accepts a request. The current mode changes, and busy falls, on the first later edge where flash_ready is 1 and clk_ready has a 1 for every enabled clock source.
- R5: A software request made while busy is 1 is rejected and sets illegal. The pending change completes to its original target.
- R6: In Halt, a 1 on irq starts a change back to the Run mode that was active before Halt.
- R7: Code 4'b1010 (Stop) is accepted only from Run0..Run3. In Stop, irq or wake starts a change back to the previous Run mode. wake has no effect in other modes.
- R8: Configuration words are written at address 1 + mode index, where the index is 0 for default run, 1..4 for Run0..3, 5 for Halt and 6 for Stop. The word holds the system clock in bits [3:0], the flash state in [5:4] and the clock enables in the bits above. The outputs show the current mode's word when idle and the target mode's word while busy.
- R9: When idle with system clock code 4'b1111 in the active word, clk_stopped is 1. Every software request is then rejected and flagged, and irq and wake are ignored, until reset.
- R10: pd_en bits 0 and 1 are always 1. Every higher bit equals the matching bit of the power word written at address 8.
- R11: illegal stays 1 once set, and is cleared by any write to address 9.
- R12: Every code other than 4'b0011, 4'b0100..4'b1000 and 4'b1010 is rejected as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 mode request, 1..7 mode words, 8 power word, 9 clear flag) |
| wr_data | input | WD | Write data |
| irq | input | 1 | Interrupt event |
| wake | input | 1 | Wakeup event |
| clk_ready | input | NCLK | Per-source clock ready |
| flash_ready | input | 1 | Flash has reached the requested state |
| cur_mode | output | 4 | Current mode code |
| busy | output | 1 | Mode change in progress |
| illegal | output | 1 | Sticky rejected-request flag |
| sysclk_sel | output | 4 | System clock selection |
| flash_mode | output | 2 | Flash power state |
| clk_src_en | output | NCLK | Clock source enables |
| pd_en | output | NDOM | Power domain enables |
| clk_stopped | output | 1 | System clock stopped, only reset exits |

## Verification
The bench builds the block with NCLK = 2 and NDOM = 5, not with the defaults. Two clock sources are enough to hold a change pending on a partly ready clock set. The narrower power word still leaves three domain bits above the two always-on ones. With these values the complete-only-when-ready rule, the target-word selection during a pending change and the domain mapping can all be seen at the ports with short vectors.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
   localparam logic [3:0] M_DRUN = 4'b0011;
   localparam logic [3:0] M_RUN0 = 4'b0100;
   localparam logic [3:0] M_RUN3 = 4'b0111;
   localparam logic [3:0] M_HALT = 4'b1000;
   localparam logic [3:0] M_STOP = 4'b1010;
   localparam logic [3:0] CLK_OFF = 4'b1111;
   localparam int NMODE = 7;
   localparam logic [3:0] A_CTRL = 4'd0;
   localparam logic [3:0] A_PWR  = 4'd8;
   localparam logic [3:0] A_CLR  = 4'd9;

   function automatic logic is_run(input logic [3:0] m);
      return (m >= M_RUN0) && (m <= M_RUN3);
   endfunction

   function automatic logic is_awake(input logic [3:0] m);
      return is_run(m) || (m == M_DRUN);
   endfunction

   function automatic logic req_legal(input logic [3:0] cur, input logic [3:0] req);
      if (req == M_DRUN || is_run(req)) return is_awake(cur);
      if (req == M_HALT || req == M_STOP) return is_run(cur);
      return 1'b0;
   endfunction

   function automatic logic [2:0] mode_idx(input logic [3:0] m);
      if (is_run(m)) return 3'(m - M_RUN0 + 4'd1);
      if (m == M_HALT) return 3'd5;
      if (m == M_STOP) return 3'd6;
      return 3'd0;
   endfunction
endpackage

// File: rtl/pmode_cfg_bank.sv
module pmode_cfg_bank #(
   parameter int CW = 9,
   parameter int NM = 7,
   parameter logic [CW-1:0] RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [2:0]    widx,
   input  logic [CW-1:0] wdata,
   input  logic [2:0]    ridx,
   output logic [CW-1:0] rdata
);
   initial begin
      if (NM < 1 || NM > 8) $error("pmode_cfg_bank: NM out of range");
   end

   logic [CW-1:0] words [NM];

   for (genvar g = 0; g < NM; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= RST;
         else if (we && widx == 3'(g))
            words[g] <= wdata;
      end
   end

   always_comb begin
      rdata = words[0];
      for (int i = 0; i < NM; i++)
         if (ridx == 3'(i)) rdata = words[i];
   end
endmodule

// File: rtl/pmode_pd.sv
module pmode_pd #(
   parameter int NDOM = 8,
   parameter int NON  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [NDOM-1:0] wdata,
   output logic [NDOM-1:0] pd_en
);
   initial begin
      if (NON < 1 || NON > NDOM) $error("pmode_pd: NON out of range");
   end

   logic [NDOM-1:0] pwr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pwr_q <= '0;
      else if (we) pwr_q <= wdata;
   end

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      if (d < NON) begin : g_on
         assign pd_en[d] = 1'b1;
      end else begin : g_sw
         assign pd_en[d] = pwr_q[d];
      end
   end
endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
   import pmode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_vld,
   input  logic [3:0] req_code,
   input  logic       irq,
   input  logic       wake,
   input  logic       cfg_ok,
   input  logic       stop_lock,
   input  logic       clr_ill,
   output logic [3:0] cur_mode,
   output logic [3:0] tgt_mode,
   output logic       busy,
   output logic       illegal
);
   logic [3:0] prev_run;
   logic       ev_hit, sw_ok, sw_bad;

   always_comb begin
      ev_hit = !busy && !stop_lock &&
               ((cur_mode == M_HALT && irq) ||
                (cur_mode == M_STOP && (irq || wake)));
      sw_ok  = req_vld && !busy && !stop_lock && !ev_hit &&
               req_legal(cur_mode, req_code);
      sw_bad = req_vld && !sw_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_mode <= M_DRUN;
         tgt_mode <= M_DRUN;
         prev_run <= M_RUN0;
         busy     <= 1'b0;
      end else if (ev_hit) begin
         tgt_mode <= prev_run;
         busy     <= 1'b1;
      end else if (sw_ok) begin
         tgt_mode <= req_code;
         busy     <= 1'b1;
      end else if (busy && cfg_ok) begin
         cur_mode <= tgt_mode;
         busy     <= 1'b0;
         if (is_run(tgt_mode)) prev_run <= tgt_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       illegal <= 1'b0;
      else if (sw_bad)  illegal <= 1'b1;
      else if (clr_ill) illegal <= 1'b0;
   end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
   import pmode_pkg::*;
#(
   parameter int NCLK = 3,
   parameter int NDOM = 8,
   parameter int WD   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [3:0]      wr_addr,
   input  logic [WD-1:0]   wr_data,
   input  logic            irq,
   input  logic            wake,
   input  logic [NCLK-1:0] clk_ready,
   input  logic            flash_ready,
   output logic [3:0]      cur_mode,
   output logic            busy,
   output logic            illegal,
   output logic [3:0]      sysclk_sel,
   output logic [1:0]      flash_mode,
   output logic [NCLK-1:0] clk_src_en,
   output logic [NDOM-1:0] pd_en,
   output logic            clk_stopped
);
   localparam int CW = 6 + NCLK;
   localparam logic [CW-1:0] CFG_RST = CW'(1) << 6;

   initial begin
      if (NCLK < 1)  $error("pmode_ctrl: NCLK must be at least 1");
      if (NDOM < 2)  $error("pmode_ctrl: NDOM must be at least 2");
      if (CW > WD)   $error("pmode_ctrl: WD too narrow for mode word");
      if (NDOM > WD) $error("pmode_ctrl: WD too narrow for power word");
   end

   logic [3:0]    tgt_mode;
   logic [CW-1:0] act_cfg;
   logic [2:0]    sel_idx;
   logic          cfg_we, pwr_we, ctl_we, clr_we, cfg_ok, stop_lock;
   logic [2:0]    cfg_idx;

   always_comb begin
      ctl_we  = wr_en && wr_addr == A_CTRL;
      pwr_we  = wr_en && wr_addr == A_PWR;
      clr_we  = wr_en && wr_addr == A_CLR;
      cfg_we  = wr_en && wr_addr >= 4'd1 && wr_addr <= 4'(NMODE);
      cfg_idx = 3'(wr_addr - 4'd1);
      sel_idx = mode_idx(busy ? tgt_mode : cur_mode);
   end

   pmode_cfg_bank #(.CW(CW), .NM(NMODE), .RST(CFG_RST)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .widx  (cfg_idx),
      .wdata (wr_data[CW-1:0]),
      .ridx  (sel_idx),
      .rdata (act_cfg)
   );

   always_comb begin
      sysclk_sel  = act_cfg[3:0];
      flash_mode  = act_cfg[5:4];
      clk_src_en  = act_cfg[CW-1:6];
      cfg_ok      = flash_ready && ((clk_ready & clk_src_en) == clk_src_en);
      stop_lock   = !busy && (sysclk_sel == CLK_OFF);
      clk_stopped = stop_lock;
   end

   pmode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vld   (ctl_we),
      .req_code  (wr_data[3:0]),
      .irq       (irq),
      .wake      (wake),
      .cfg_ok    (cfg_ok),
      .stop_lock (stop_lock),
      .clr_ill   (clr_we),
      .cur_mode  (cur_mode),
      .tgt_mode  (tgt_mode),
      .busy      (busy),
      .illegal   (illegal)
   );

   pmode_pd #(.NDOM(NDOM), .NON(2)) u_pd (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pwr_we),
      .wdata (wr_data[NDOM-1:0]),
      .pd_en (pd_en)
   );
endmodule

// File: rtl/pmode_chk.sv
module pmode_chk
   import pmode_pkg::*;
#(
   parameter int NDOM = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [3:0]      wr_addr,
   input logic            flash_ready,
   input logic [3:0]      cur_mode,
   input logic            busy,
   input logic            illegal,
   input logic [NDOM-1:0] pd_en,
   input logic            clk_stopped
);
   AST_DOMS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      pd_en[1:0] == 2'b11); // R10

   AST_HALT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == M_HALT && $past(cur_mode) != M_HALT) |-> is_run($past(cur_mode))); // R3

   AST_MODE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode != $past(cur_mode)) |-> $fell(busy)); // R4

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(flash_ready)); // R4

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_stopped && !busy) |=> (!busy && $stable(cur_mode))); // R9

   AST_ILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !(wr_en && wr_addr == A_CLR)) |=> illegal); // R11
endmodule

bind pmode_ctrl pmode_chk #(.NDOM(NDOM)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .flash_ready (flash_ready),
   .cur_mode    (cur_mode),
   .busy        (busy),
   .illegal     (illegal),
   .pd_en       (pd_en),
   .clk_stopped (clk_stopped)
);

// File: tb/sim_pmode_ctrl.sv
module sim_pmode_ctrl;
   localparam int NCLK = 2;
   localparam int NDOM = 5;
   localparam int WD   = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [3:0]      wr_addr = '0;
   logic [WD-1:0]   wr_data = '0;
   logic            irq = 1'b0, wake = 1'b0;
   logic [NCLK-1:0] clk_ready = '1;
   logic            flash_ready = 1'b1;
   logic [3:0]      cur_mode;
   logic            busy, illegal, clk_stopped;
   logic [3:0]      sysclk_sel;
   logic [1:0]      flash_mode;
   logic [NCLK-1:0] clk_src_en;
   logic [NDOM-1:0] pd_en;

   int n_chk = 0, n_bad = 0, cyc = 0;

   pmode_ctrl #(.NCLK(NCLK), .NDOM(NDOM), .WD(WD)) u0 (.*);

   always #10 clk = ~clk;

   // kind[10:9] (0 sw, 1 irq, 2 wake), code[8:5], exp mode[4:1], exp illegal[0]
   localparam int NV = 16;
   localparam logic [10:0] VEC [NV] = '{
      {2'd0, 4'b1000, 4'b0011, 1'b1},  // R3 halt from default run
      {2'd0, 4'b0101, 4'b0101, 1'b0},  // R2
      {2'd0, 4'b0111, 4'b0111, 1'b0},  // R2
      {2'd0, 4'b1000, 4'b1000, 1'b0},  // R3
      {2'd0, 4'b0100, 4'b1000, 1'b1},  // R3 run from halt rejected
      {2'd1, 4'b0000, 4'b0111, 1'b0},  // R6
      {2'd0, 4'b1010, 4'b1010, 1'b0},  // R7
      {2'd2, 4'b0000, 4'b0111, 1'b0},  // R7 wake
      {2'd0, 4'b1010, 4'b1010, 1'b0},  // R7
      {2'd1, 4'b0000, 4'b0111, 1'b0},  // R7 irq
      {2'd0, 4'b0011, 4'b0011, 1'b0},  // R2
      {2'd0, 4'b1010, 4'b0011, 1'b1},  // R7 stop from default run
      {2'd0, 4'b1111, 4'b0011, 1'b1},  // R12
      {2'd0, 4'b0000, 4'b0011, 1'b1},  // R12
      {2'd0, 4'b0110, 4'b0110, 1'b0},  // R2
      {2'd2, 4'b0000, 4'b0110, 1'b0}   // R7 wake ignored in run
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [WD-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_irq(input logic w);
      if (w) wake = 1'b1; else irq = 1'b1;
      @(negedge clk);
      irq = 1'b0; wake = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         finish_run();
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R1 reset state
      chk("R1 mode", 32'(cur_mode), 32'h3);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 illegal", 32'(illegal), 0);
      chk("R1 sysclk", 32'(sysclk_sel), 0);
      chk("R1 flash", 32'(flash_mode), 0);
      chk("R1 clken", 32'(clk_src_en), 32'h1);
      chk("R10 pd reset", 32'(pd_en), 32'h03);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         wr(4'd9, '0);
         if (VEC[i][10:9] == 2'd0) wr(4'd0, WD'(VEC[i][8:5]));
         else pulse_irq(VEC[i][10:9] == 2'd2);
         @(negedge clk);
         chk($sformatf("R2/R3/R6/R7/R12 vec%0d mode", i), 32'(cur_mode), 32'(VEC[i][4:1]));
         chk($sformatf("R3/R12 vec%0d illegal", i), 32'(illegal), 32'(VEC[i][0]));
         chk($sformatf("R4 vec%0d busy", i), 32'(busy), 0);
      end

      // R11 sticky and cleared
      wr(4'd0, 4'b1111);
      repeat (3) @(negedge clk);
      chk("R11 sticky", 32'(illegal), 1);
      wr(4'd9, '0);
      chk("R11 cleared", 32'(illegal), 0);

      // R8 target word while busy, R4 hold until ready
      wr(4'd2, WD'({2'b11, 2'b01, 4'd5}));
      flash_ready = 1'b0;
      wr(4'd0, 4'b0100);
      chk("R4 busy after accept", 32'(busy), 1);
      chk("R8 target sysclk while busy", 32'(sysclk_sel), 5);
      chk("R8 target clken while busy", 32'(clk_src_en), 32'h3);
      wr(4'd0, 4'b0101);
      chk("R5 illegal while busy", 32'(illegal), 1);
      flash_ready = 1'b1; clk_ready = 2'b01;
      repeat (2) @(negedge clk);
      chk("R4 wait clk ready", 32'(cur_mode), 32'h6);
      chk("R4 still busy", 32'(busy), 1);
      clk_ready = 2'b11;
      @(negedge clk);
      chk("R5 original target", 32'(cur_mode), 32'h4);
      chk("R8 idle sysclk", 32'(sysclk_sel), 5);
      chk("R8 idle flash", 32'(flash_mode), 1);

      // R10 power word
      wr(4'd8, WD'(5'b10100));
      chk("R10 pd word", 32'(pd_en), 32'h17);
      wr(4'd8, '0);
      chk("R10 pd cleared", 32'(pd_en), 32'h03);

      // R9 clock stop lock
      wr(4'd9, '0);
      wr(4'd5, WD'({2'b01, 2'b00, 4'b1111}));
      wr(4'd0, 4'b0111);
      @(negedge clk);
      chk("R9 in run3", 32'(cur_mode), 32'h7);
      chk("R9 stopped", 32'(clk_stopped), 1);
      wr(4'd0, 4'b0100);
      @(negedge clk);
      chk("R9 request rejected", 32'(illegal), 1);
      chk("R9 mode held", 32'(cur_mode), 32'h7);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset exits", 32'(cur_mode), 32'h3);
      chk("R9 stop cleared", 32'(clk_stopped), 0);

      finish_run();
   end
endmodule